// File: doc/BRIEF.md
# Byte Arithmetic and Logic Unit with Status Flags

This block is the purely combinational execute stage of a small 8-bit RISC core. Each cycle the core presents two operand bytes, a 5-bit operation select and its current status byte. The block returns the result byte, a new status byte and a write mask that tells the core which status bits the operation really updates. The first operand is the destination register. The second operand is either a register or an immediate. Single-operand operations use only the first operand.

The operations are add and subtract with and without carry, compare with and without carry, the three bitwise logic operations, one's and two's complement, increment and decrement, logical and arithmetic shifts, rotates through carry, and nibble swap. Each operation has its own fixed set of flags that it updates. The carry-using subtract and compare keep the zero flag sticky, so a compare of a multi-byte value can be built from a chain of byte compares. Any bit that the mask does not select is passed through from the incoming status byte unchanged.

Top module: `alu8_core`

## Requirements
- R1: The status byte holds, from bit 7 down to bit 0: I, T, H, S, V, N, Z, C. Mask bits 7 and 6 are never set. For every bit whose mask bit is 0, `flag_out` equals `flag_in`.
- R2: ADD (0) gives a+b and ADC (1) gives a+b+C. C is the carry out of bit 7, H is the carry out of bit 3 and V is two's complement overflow. The mask is 0x3F.
- R3: SUB (2) and CP (4) give a-b. SBC (3) and CPC (5) give a-b-C. C is the borrow out of bit 7, H is the borrow out of bit 3 and V is signed overflow. The compare codes output the same difference on `result`. The mask is 0x3F.
- R4: For SUB and CP, Z is set exactly when the result is zero. For SBC and CPC, Z is set only if the result is zero and the incoming Z was set.
- R5: AND (6), OR (7) and XOR (8) clear V and set N and Z from the result. The mask is 0x1E.
- R6: COM (9) returns 0xFF minus a, sets C and clears V. The mask is 0x1F.
- R7: NEG (10) returns 0x00 minus a. C is set when a is nonzero, H is set when bit 3 of either a or the result is set, and V is set only for a result of 0x80. The mask is 0x3F.
- R8: INC (11) and DEC (12) add or subtract one. V is set only for 0x7F to 0x80 (INC) or 0x80 to 0x7F (DEC). The mask is 0x1E, so C and H are left unchanged.
- R9: The shift codes are LSR (13), ROR (14), ASR (15), LSL (16) and ROL (17). LSR fills bit 7 with 0, ROR fills it with C and ASR keeps it. LSL fills bit 0 with 0 and ROL fills it with C. The bit shifted out becomes C, and V = N XOR C. The mask is 0x1F.
- R10: SWAP (18) exchanges bits 7:4 with bits 3:0 and has mask 0.
- R11: Whenever S is written, S = N XOR V.
- R12: Codes 19 to 31 are not defined. They return operand a unchanged and have mask 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opr_a | input | WIDTH | Destination operand, also the only operand of unary operations |
| opr_b | input | WIDTH | Second operand, register or immediate |
| op_sel | input | 5 | Operation select code |
| flag_in | input | 8 | Current status byte |
| result | output | WIDTH | Result byte |
| flag_out | output | 8 | Status byte after the operation |
| flag_we | output | 8 | Per-bit write mask for the status byte |

## Verification
Two effects fall on the same compare-with-carry operation: the incoming carry is subtracted, and the incoming zero flag is kept sticky. The bench provokes both by chaining byte compares of 16-bit values. The expected status byte of the low-byte compare is fed back as `flag_in` for the high-byte compare, using pairs that are equal, that differ only in the low byte, and that borrow across the byte boundary. Every step is judged against a model written with integer arithmetic, so the carry, zero and overflow flags and the mask are all checked together.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int OP_W   = 5;
    localparam int FLAG_W = 8;

    // status bit positions (these matter to the core that decodes them)
    localparam int FB_C = 0;
    localparam int FB_Z = 1;
    localparam int FB_N = 2;
    localparam int FB_V = 3;
    localparam int FB_S = 4;
    localparam int FB_H = 5;

    localparam logic [FLAG_W-1:0] MASK_ARITH = 8'b0011_1111;
    localparam logic [FLAG_W-1:0] MASK_LOGIC = 8'b0001_1110;
    localparam logic [FLAG_W-1:0] MASK_SHIFT = 8'b0001_1111;
    localparam logic [FLAG_W-1:0] MASK_NONE  = 8'b0000_0000;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 5'd0,
        OP_ADC  = 5'd1,
        OP_SUB  = 5'd2,
        OP_SBC  = 5'd3,
        OP_CP   = 5'd4,
        OP_CPC  = 5'd5,
        OP_AND  = 5'd6,
        OP_OR   = 5'd7,
        OP_XOR  = 5'd8,
        OP_COM  = 5'd9,
        OP_NEG  = 5'd10,
        OP_INC  = 5'd11,
        OP_DEC  = 5'd12,
        OP_LSR  = 5'd13,
        OP_ROR  = 5'd14,
        OP_ASR  = 5'd15,
        OP_LSL  = 5'd16,
        OP_ROL  = 5'd17,
        OP_SWAP = 5'd18
    } alu_op_e;

    typedef enum logic [1:0] {
        UNIT_ARITH,
        UNIT_LOGIC,
        UNIT_SHIFT,
        UNIT_PASS
    } unit_e;

    typedef enum logic [2:0] {
        LG_AND,
        LG_OR,
        LG_XOR,
        LG_INV,
        LG_SWAP
    } logic_e;

    typedef enum logic [2:0] {
        SH_LSR,
        SH_ROR,
        SH_ASR,
        SH_LSL,
        SH_ROL
    } shift_e;

    typedef enum logic [1:0] {
        XS_A,
        XS_ZERO
    } xsel_e;

    typedef enum logic [1:0] {
        YS_B,
        YS_A,
        YS_ZERO
    } ysel_e;

    typedef enum logic [1:0] {
        CI_ZERO,
        CI_FLAG,
        CI_ONE
    } cisel_e;

    typedef enum logic [1:0] {
        VR_UNIT,
        VR_CLEAR,
        VR_NXORC
    } vrule_e;

    typedef struct packed {
        logic i;
        logic t;
        logic h;
        logic s;
        logic v;
        logic n;
        logic z;
        logic c;
    } sreg_t;

    typedef struct packed {
        logic h;
        logic v;
        logic c;
    } raw_flags_t;

    typedef struct packed {
        unit_e             unit;
        xsel_e             xsel;
        ysel_e             ysel;
        cisel_e            cisel;
        logic              sub;
        logic              sticky_z;
        vrule_e            vrule;
        logic              c_force;
        logic_e            lop;
        shift_e            sop;
        logic [FLAG_W-1:0] mask;
    } ctrl_t;

    function automatic ctrl_t decode(input logic [OP_W-1:0] code);
        ctrl_t k;
        k.unit     = UNIT_PASS;
        k.xsel     = XS_A;
        k.ysel     = YS_B;
        k.cisel    = CI_ZERO;
        k.sub      = 1'b0;
        k.sticky_z = 1'b0;
        k.vrule    = VR_UNIT;
        k.c_force  = 1'b0;
        k.lop      = LG_AND;
        k.sop      = SH_LSR;
        k.mask     = MASK_NONE;
        case (alu_op_e'(code))
            OP_ADD: begin
                k.unit = UNIT_ARITH;
                k.mask = MASK_ARITH;
            end
            OP_ADC: begin
                k.unit  = UNIT_ARITH;
                k.cisel = CI_FLAG;
                k.mask  = MASK_ARITH;
            end
            OP_SUB, OP_CP: begin
                k.unit = UNIT_ARITH;
                k.sub  = 1'b1;
                k.mask = MASK_ARITH;
            end
            OP_SBC, OP_CPC: begin
                k.unit     = UNIT_ARITH;
                k.sub      = 1'b1;
                k.cisel    = CI_FLAG;
                k.sticky_z = 1'b1;
                k.mask     = MASK_ARITH;
            end
            OP_AND: begin
                k.unit  = UNIT_LOGIC;
                k.lop   = LG_AND;
                k.vrule = VR_CLEAR;
                k.mask  = MASK_LOGIC;
            end
            OP_OR: begin
                k.unit  = UNIT_LOGIC;
                k.lop   = LG_OR;
                k.vrule = VR_CLEAR;
                k.mask  = MASK_LOGIC;
            end
            OP_XOR: begin
                k.unit  = UNIT_LOGIC;
                k.lop   = LG_XOR;
                k.vrule = VR_CLEAR;
                k.mask  = MASK_LOGIC;
            end
            OP_COM: begin
                k.unit    = UNIT_LOGIC;
                k.lop     = LG_INV;
                k.vrule   = VR_CLEAR;
                k.c_force = 1'b1;
                k.mask    = MASK_SHIFT;
            end
            OP_NEG: begin
                k.unit = UNIT_ARITH;
                k.xsel = XS_ZERO;
                k.ysel = YS_A;
                k.sub  = 1'b1;
                k.mask = MASK_ARITH;
            end
            OP_INC: begin
                k.unit  = UNIT_ARITH;
                k.ysel  = YS_ZERO;
                k.cisel = CI_ONE;
                k.mask  = MASK_LOGIC;
            end
            OP_DEC: begin
                k.unit  = UNIT_ARITH;
                k.ysel  = YS_ZERO;
                k.cisel = CI_ONE;
                k.sub   = 1'b1;
                k.mask  = MASK_LOGIC;
            end
            OP_LSR, OP_ROR, OP_ASR, OP_LSL, OP_ROL: begin
                k.unit  = UNIT_SHIFT;
                k.vrule = VR_NXORC;
                k.mask  = MASK_SHIFT;
                case (alu_op_e'(code))
                    OP_ROR:  k.sop = SH_ROR;
                    OP_ASR:  k.sop = SH_ASR;
                    OP_LSL:  k.sop = SH_LSL;
                    OP_ROL:  k.sop = SH_ROL;
                    default: k.sop = SH_LSR;
                endcase
            end
            OP_SWAP: begin
                k.unit = UNIT_LOGIC;
                k.lop  = LG_SWAP;
            end
            default: begin
                k.unit = UNIT_PASS;
            end
        endcase
        return k;
    endfunction

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0]     x,
    input  logic [WIDTH-1:0]     y,
    input  logic                 sub,
    input  logic                 ci,
    output logic [WIDTH-1:0]     sum,
    output alu8_pkg::raw_flags_t fl
);
    localparam int HALF = WIDTH / 2;

    logic [WIDTH:0]   cy;
    logic [WIDTH-1:0] yy;

    // subtraction: add the inverted operand, carry-in is the inverted borrow-in
    assign yy    = sub ? ~y : y;
    assign cy[0] = sub ? ~ci : ci;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign sum[i]  = x[i] ^ yy[i] ^ cy[i];
        assign cy[i+1] = (x[i] & yy[i]) | (cy[i] & (x[i] ^ yy[i]));
    end

    // carries turn into borrows when subtracting
    assign fl.h = cy[HALF] ^ sub;
    assign fl.c = cy[WIDTH] ^ sub;
    assign fl.v = cy[WIDTH] ^ cy[WIDTH-1];

endmodule

// File: rtl/alu8_logic.sv
module alu8_logic #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  alu8_pkg::logic_e lop,
    output logic [WIDTH-1:0] res
);
    import alu8_pkg::*;

    localparam int HALF = WIDTH / 2;

    always_comb begin
        case (lop)
            LG_AND:  res = a & b;
            LG_OR:   res = a | b;
            LG_XOR:  res = a ^ b;
            LG_INV:  res = ~a;
            LG_SWAP: res = {a[HALF-1:0], a[WIDTH-1:HALF]};
            default: res = a;
        endcase
    end

endmodule

// File: rtl/alu8_shift.sv
module alu8_shift #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic             ci,
    input  alu8_pkg::shift_e sop,
    output logic [WIDTH-1:0] res,
    output logic             co
);
    import alu8_pkg::*;

    logic to_left;
    logic fill;

    always_comb begin
        to_left = 1'b0;
        fill    = 1'b0;
        case (sop)
            SH_ROR:  fill = ci;
            SH_ASR:  fill = a[WIDTH-1];
            SH_LSL:  to_left = 1'b1;
            SH_ROL:  begin
                to_left = 1'b1;
                fill    = ci;
            end
            default: fill = 1'b0;
        endcase
    end

    always_comb begin
        if (to_left) begin
            res = {a[WIDTH-2:0], fill};
            co  = a[WIDTH-1];
        end else begin
            res = {fill, a[WIDTH-1:1]};
            co  = a[0];
        end
    end

endmodule

// File: rtl/alu8_core.sv
module alu8_core #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0]          opr_a,
    input  logic [WIDTH-1:0]          opr_b,
    input  logic [alu8_pkg::OP_W-1:0] op_sel,
    input  logic [7:0]                flag_in,
    output logic [WIDTH-1:0]          result,
    output logic [7:0]                flag_out,
    output logic [7:0]                flag_we
);
    import alu8_pkg::*;

    ctrl_t            ctl;
    sreg_t            cur;
    sreg_t            nxt;
    logic [WIDTH-1:0] ax_x;
    logic [WIDTH-1:0] ax_y;
    logic             ax_ci;
    logic [WIDTH-1:0] ax_sum;
    raw_flags_t       ax_fl;
    logic [WIDTH-1:0] lg_res;
    logic [WIDTH-1:0] sh_res;
    logic             sh_co;
    logic             res_zero;

    assign ctl = decode(op_sel);
    assign cur = sreg_t'(flag_in);

    // operand steering for the shared adder
    always_comb begin
        case (ctl.xsel)
            XS_ZERO: ax_x = '0;
            default: ax_x = opr_a;
        endcase
        case (ctl.ysel)
            YS_A:    ax_y = opr_a;
            YS_ZERO: ax_y = '0;
            default: ax_y = opr_b;
        endcase
        case (ctl.cisel)
            CI_FLAG: ax_ci = cur.c;
            CI_ONE:  ax_ci = 1'b1;
            default: ax_ci = 1'b0;
        endcase
    end

    alu8_addsub #(.WIDTH(WIDTH)) u_addsub (
        .x   (ax_x),
        .y   (ax_y),
        .sub (ctl.sub),
        .ci  (ax_ci),
        .sum (ax_sum),
        .fl  (ax_fl)
    );

    alu8_logic #(.WIDTH(WIDTH)) u_logic (
        .a   (opr_a),
        .b   (opr_b),
        .lop (ctl.lop),
        .res (lg_res)
    );

    alu8_shift #(.WIDTH(WIDTH)) u_shift (
        .a   (opr_a),
        .ci  (cur.c),
        .sop (ctl.sop),
        .res (sh_res),
        .co  (sh_co)
    );

    always_comb begin
        case (ctl.unit)
            UNIT_ARITH: result = ax_sum;
            UNIT_LOGIC: result = lg_res;
            UNIT_SHIFT: result = sh_res;
            default:    result = opr_a;
        endcase
    end

    assign res_zero = (result == '0);

    // candidate status byte before masking
    always_comb begin
        nxt   = cur;
        nxt.n = result[WIDTH-1];
        nxt.z = ctl.sticky_z ? (res_zero & cur.z) : res_zero;
        nxt.h = ax_fl.h;
        case (ctl.unit)
            UNIT_ARITH: nxt.c = ax_fl.c;
            UNIT_SHIFT: nxt.c = sh_co;
            default:    nxt.c = ctl.c_force;
        endcase
        case (ctl.vrule)
            VR_CLEAR: nxt.v = 1'b0;
            VR_NXORC: nxt.v = nxt.n ^ nxt.c;
            default:  nxt.v = ax_fl.v;
        endcase
        nxt.s = nxt.n ^ nxt.v;
    end

    assign flag_we  = ctl.mask;
    assign flag_out = (nxt & ctl.mask) | (flag_in & ~ctl.mask);

endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk #(
    parameter int WIDTH = 8
) (
    input logic [WIDTH-1:0]          opr_a,
    input logic [WIDTH-1:0]          opr_b,
    input logic [alu8_pkg::OP_W-1:0] op_sel,
    input logic [7:0]                flag_in,
    input logic [WIDTH-1:0]          result,
    input logic [7:0]                flag_out,
    input logic [7:0]                flag_we
);
    import alu8_pkg::*;

    logic known;
    assign known = !$isunknown({opr_a, opr_b, op_sel, flag_in, result, flag_out, flag_we});

    always_comb begin
        if (known) begin
            // R1
            it_keep_chk: assert (flag_we[7:6] == 2'b00 && flag_out[7:6] == flag_in[7:6]);
            // R1
            unmasked_pass_chk: assert (((flag_out ^ flag_in) & ~flag_we) == 8'h00);
            // R11
            sign_rule_chk: assert (!flag_we[FB_S] ||
                                   flag_out[FB_S] == (flag_out[FB_N] ^ flag_out[FB_V]));
            // R4
            sticky_zero_chk: assert (!(op_sel == OP_SBC || op_sel == OP_CPC) ||
                                     !flag_out[FB_Z] || (flag_in[FB_Z] && result == '0));
            // R6
            com_carry_chk: assert (op_sel != OP_COM ||
                                   (flag_out[FB_C] && !flag_out[FB_V]));
            // R8
            incdec_keep_chk: assert (!(op_sel == OP_INC || op_sel == OP_DEC) ||
                                     (!flag_we[FB_C] && !flag_we[FB_H]));
            // R9
            shift_v_chk: assert (!(op_sel >= OP_LSR && op_sel <= OP_ROL) ||
                                 flag_out[FB_V] == (flag_out[FB_N] ^ flag_out[FB_C]));
            // R10
            quiet_op_chk: assert (op_sel < OP_SWAP || flag_we == 8'h00);
        end
    end

endmodule

bind alu8_core alu8_core_chk #(.WIDTH(WIDTH)) u_chk (
    .opr_a    (opr_a),
    .opr_b    (opr_b),
    .op_sel   (op_sel),
    .flag_in  (flag_in),
    .result   (result),
    .flag_out (flag_out),
    .flag_we  (flag_we)
);

// File: tb/alu8_core_tb.sv
module alu8_core_tb;

    typedef struct {
        int         op;
        logic [7:0] a;
        logic [7:0] b;
        logic [7:0] fin;
        logic [7:0] r;
        logic [7:0] f;
        logic [7:0] m;
    } item_t;

    logic       clk = 1'b0;
    logic [7:0] opr_a = 8'h00;
    logic [7:0] opr_b = 8'h00;
    logic [4:0] op_sel = 5'd0;
    logic [7:0] flag_in = 8'h00;
    logic [7:0] result;
    logic [7:0] flag_out;
    logic [7:0] flag_we;

    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    item_t sb_q[$];

    always #5 clk = ~clk;

    alu8_core u_dut (
        .opr_a    (opr_a),
        .opr_b    (opr_b),
        .op_sel   (op_sel),
        .flag_in  (flag_in),
        .result   (result),
        .flag_out (flag_out),
        .flag_we  (flag_we)
    );

    function automatic int sx(input int v);
        return (v > 127) ? v - 256 : v;
    endfunction

    function automatic string tag_of(input int op);
        case (op)
            0, 1:              return "R2";
            2, 4:              return "R3";
            3, 5:              return "R4";
            6, 7, 8:           return "R5";
            9:                 return "R6";
            10:                return "R7";
            11, 12:            return "R8";
            13, 14, 15, 16, 17: return "R9";
            18:                return "R10";
            default:           return "R12";
        endcase
    endfunction

    // independent model built from the requirements with integer arithmetic
    function automatic item_t model(input int op, input logic [7:0] a8,
                                    input logic [7:0] b8, input logic [7:0] fin);
        item_t it;
        int a = int'(a8);
        int b = int'(b8);
        int ci = int'(fin[0]);
        int k = 0;
        int s = 0;
        int r = 0;
        logic h = 1'b0, v = 1'b0, c = 1'b0, n, z;
        logic [7:0] m = 8'h00;
        logic [7:0] nv;
        case (op)
            0, 1: begin
                k = (op == 1) ? ci : 0;
                s = a + b + k;
                r = s % 256;
                c = (s > 255);
                h = ((a % 16) + (b % 16) + k) > 15;
                s = sx(a) + sx(b) + k;
                v = (s > 127) || (s < -128);
                m = 8'h3F;
            end
            2, 3, 4, 5: begin
                k = (op == 3 || op == 5) ? ci : 0;
                s = a - b - k;
                r = (s + 512) % 256;
                c = (s < 0);
                h = ((a % 16) - (b % 16) - k) < 0;
                s = sx(a) - sx(b) - k;
                v = (s > 127) || (s < -128);
                m = 8'h3F;
            end
            6: begin r = int'(a8 & b8); m = 8'h1E; end
            7: begin r = int'(a8 | b8); m = 8'h1E; end
            8: begin r = int'(a8 ^ b8); m = 8'h1E; end
            9: begin r = 255 - a; c = 1'b1; m = 8'h1F; end
            10: begin
                r = (256 - a) % 256;
                c = (a != 0);
                h = ((a % 16) != 0);
                v = (a == 128);
                m = 8'h3F;
            end
            11: begin r = (a + 1) % 256; v = (a == 127); m = 8'h1E; end
            12: begin r = (a + 255) % 256; v = (a == 128); m = 8'h1E; end
            13: begin r = a / 2; c = a8[0]; m = 8'h1F; end
            14: begin r = a / 2 + 128 * ci; c = a8[0]; m = 8'h1F; end
            15: begin r = a / 2 + (a >= 128 ? 128 : 0); c = a8[0]; m = 8'h1F; end
            16: begin r = (a * 2) % 256; c = a8[7]; m = 8'h1F; end
            17: begin r = (a * 2 + ci) % 256; c = a8[7]; m = 8'h1F; end
            18: begin r = (a % 16) * 16 + a / 16; m = 8'h00; end
            default: begin r = a; m = 8'h00; end
        endcase
        n = (r >= 128);
        z = (r == 0);
        if (op == 3 || op == 5) z = z && fin[1];
        if (op >= 13 && op <= 17) v = n ^ c;
        nv = {fin[7:6], h, n ^ v, v, n, z, c};
        it.op  = op;
        it.a   = a8;
        it.b   = b8;
        it.fin = fin;
        it.r   = 8'(r);
        it.m   = m;
        it.f   = (nv & m) | (fin & ~m);
        return it;
    endfunction

    task automatic drive(input int op, input logic [7:0] a, input logic [7:0] b,
                         input logic [7:0] fin, output logic [7:0] fexp);
        item_t it;
        @(negedge clk);
        opr_a   = a;
        opr_b   = b;
        op_sel  = 5'(op);
        flag_in = fin;
        it = model(op, a, b, fin);
        fexp = it.f;
        sb_q.push_back(it);
    endtask

    // monitor: compares at the rising edge, half a period after the driver
    always @(posedge clk) begin
        if (sb_q.size() > 0) begin
            item_t e;
            e = sb_q.pop_front();
            n_chk++;
            if (result !== e.r || flag_out !== e.f || flag_we !== e.m) begin
                n_fail++;
                $display("FAIL %s op=%0d a=%h b=%h fin=%h: actual r=%h f=%h m=%h expected r=%h f=%h m=%h",
                         tag_of(e.op), e.op, e.a, e.b, e.fin,
                         result, flag_out, flag_we, e.r, e.f, e.m);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R1 watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] f;
        logic [31:0] lfsr;
        lfsr = 32'h1ACE_B00C;
        repeat (3) @(posedge clk);

        // R1: idle inputs, all zero, with I and T set to show they pass through
        drive(0, 8'h00, 8'h00, 8'h00, f);
        drive(6, 8'h00, 8'h00, 8'hC0, f);

        // R2: half carry, full carry, signed overflow
        drive(0, 8'h0F, 8'h01, 8'h00, f);
        drive(0, 8'h7F, 8'h01, 8'h00, f);
        drive(0, 8'hFF, 8'h01, 8'h00, f);
        drive(1, 8'hFF, 8'h00, 8'h01, f);
        drive(1, 8'h80, 8'h80, 8'h01, f);

        // R3: borrows and overflow on subtract
        drive(2, 8'h10, 8'h01, 8'h00, f);
        drive(2, 8'h80, 8'h01, 8'h00, f);
        drive(4, 8'h00, 8'h01, 8'h00, f);

        // R4: chained 16-bit compares, carry and sticky zero in one step
        drive(4, 8'h34, 8'h34, 8'h00, f);
        drive(5, 8'h12, 8'h12, f, f);
        drive(4, 8'h35, 8'h34, 8'h00, f);
        drive(5, 8'h12, 8'h12, f, f);
        drive(4, 8'h00, 8'h01, 8'h00, f);
        drive(5, 8'h13, 8'h12, f, f);
        drive(3, 8'h01, 8'h00, 8'h03, f);
        drive(3, 8'h01, 8'h00, 8'h01, f);

        // R5 logic, R6 complement
        drive(6, 8'hF0, 8'h0F, 8'h08, f);
        drive(7, 8'h80, 8'h01, 8'h08, f);
        drive(8, 8'hAA, 8'hAA, 8'h3F, f);
        drive(9, 8'hFF, 8'h00, 8'h00, f);
        drive(9, 8'h00, 8'h00, 8'h00, f);

        // R7 negate boundary values
        drive(10, 8'h00, 8'h00, 8'h3F, f);
        drive(10, 8'h80, 8'h00, 8'h00, f);
        drive(10, 8'h01, 8'h00, 8'h00, f);

        // R8 increment and decrement edges, C and H must survive
        drive(11, 8'h7F, 8'h00, 8'h21, f);
        drive(11, 8'hFF, 8'h00, 8'h00, f);
        drive(12, 8'h80, 8'h00, 8'h21, f);
        drive(12, 8'h00, 8'h00, 8'h00, f);

        // R9 shifts and rotates with carry in both states
        drive(13, 8'h81, 8'h00, 8'h00, f);
        drive(14, 8'h02, 8'h00, 8'h01, f);
        drive(15, 8'h81, 8'h00, 8'h00, f);
        drive(16, 8'hC0, 8'h00, 8'h00, f);
        drive(17, 8'h40, 8'h00, 8'h01, f);

        // R10 swap, R12 undefined codes
        drive(18, 8'h5A, 8'h00, 8'hFF, f);
        drive(19, 8'h3C, 8'hC3, 8'h55, f);
        drive(31, 8'h00, 8'hFF, 8'hAA, f);

        // R11 and all the rest: pseudo-random sweep over every code
        for (int i = 0; i < 3000; i++) begin
            lfsr = lfsr ^ (lfsr << 13);
            lfsr = lfsr ^ (lfsr >> 17);
            lfsr = lfsr ^ (lfsr << 5);
            drive(i % 32, lfsr[7:0], lfsr[15:8], lfsr[23:16], f);
        end

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule